// File: doc/BRIEF.md
# Two-Wire Block-Write Clock Configuration Slave

This block is a write-only slave on a two-wire serial bus. It holds the enable settings of a clock generator: one spread-spectrum switch and one enable for each clock output that software may turn off. A bus host changes these settings with block-write transfers. The host sends the address byte, a command byte and a count byte, then the data bytes. The command byte has no effect. Data lands in register bytes 0, 1 and 2 in that order, and a transfer may stop after any whole byte.

Both bus lines are sampled in the system clock domain through two-flop synchronizers. Start and stop conditions and clock edges are found from the synchronized samples. The slave acknowledges by asking the pad to pull the data line low, through an open-drain output enable. It never stretches the clock and never returns data.

Top module: `cfgwr_slave`

## Requirements
- R1: After reset, every clock enable output is 1, spread spectrum is 0 and the data line is released (`sda_oe_o` = 0).
- R2: The slave acknowledges the address byte 8'hD2 (seven-bit address plus write bit 0). It does not acknowledge any other address byte, and the rest of such a transfer has no effect on any output.
- R3: The first byte after the address is acknowledged and its value has no effect.
- R4: The second byte after the address is the count. It is acknowledged. Data bytes are received most significant bit first and written in order to register bytes 0, 1, 2, starting at byte 0 in every transfer.
- R5: A count of 0 or a count above 32 is still acknowledged, but every data byte that follows it is ignored.
- R6: Data bytes past the count, and data bytes at position 3 or higher, are acknowledged but change no output.
- R7: A stop after any whole byte ends the transfer. Bytes already written keep their new values and later bytes keep their old ones.
- R8: In register byte 0, bit 3 drives `ss_en_o`, bit 2 drives `dot_en_o` and bit 1 drives `usb_en_o`. The other bits of byte 0 have no effect.
- R9: Register byte 1 bits 7..0 drive `mem_en_o[7:0]`. In byte 2, bit 7 drives `agp_en_o`, bits 6..2 drive `mem_en_o[12:8]` and bit 1 drives `pci1_en_o`. Bit 0 of byte 2 has no effect.
- R10: `sda_oe_o` is raised only for the acknowledge bit of an accepted byte. It is dropped after the ninth clock falls, or at once when a stop is seen.
- R11: A repeated start restarts decoding at the address byte, with the data position back at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| ss_en_o | output | 1 | Spread-spectrum enable |
| dot_en_o | output | 1 | Dot clock enable |
| usb_en_o | output | 1 | 48 MHz USB clock enable |
| agp_en_o | output | 1 | Graphics-port 66 MHz clock enable |
| pci1_en_o | output | 1 | Second PCI clock enable |
| mem_en_o | output | 13 | Memory clock enables |

## Verification
Directed transfers cover the cases that separate correct decoding from near misses:
- a full three-byte write, which pins down the bit mapping and MSB-first order;
- a foreign address, which must be ignored;
- counts of 0 and 33;
- a count shorter than the data sent, which shows that data stops at the count;
- a stop right after byte 0;
- a repeated start, which must restart at byte 0.

Random transfers then vary the address, count, number of bytes sent and data values. They are checked against a bench model of the three registers. The acknowledge of every byte is compared with whether the address matched, so a wrong ack or a write to the wrong byte shows up.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;
    localparam int NREG  = 3;
    localparam int IDX_W = $clog2(NREG);
    localparam int MEM_N = 13;
    localparam logic [7:0] DEV_ADDR  = 8'hD2;
    localparam logic [7:0] MAX_COUNT = 8'd32;
    localparam logic [NREG-1:0][7:0] RST_VAL  = {8'hFE, 8'hFF, 8'h06};
    localparam logic [NREG-1:0][7:0] BIT_MASK = {8'hFE, 8'hFF, 8'h0E};

    typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK, ST_IGNORE} link_st_e;
    typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} byte_kind_e;

    typedef struct packed {
        link_st_e        st;
        byte_kind_e      kind;
        logic [3:0]      nbits;
        logic [7:0]      shf;
        logic            oe;
        logic            cnt_ok;
        logic [5:0]      left;
        logic [5:0]      idx;
        logic            wr;
        logic [IDX_W-1:0] widx;
        logic [7:0]      wdata;
    } link_s;
endpackage

// File: rtl/cfgwr_sync.sv
module cfgwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb chain_d = {chain_q[STAGES-1:0], d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q      = chain_q[STAGES-1];
    assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/cfgwr_link.sv
module cfgwr_link
    import cfgwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    link_s q, d;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st     = ST_RECV;
            d.kind   = K_ADDR;
            d.nbits  = '0;
            d.oe     = 1'b0;
            d.cnt_ok = 1'b0;
            d.left   = '0;
            d.idx    = '0;
        end else begin
            case (q.st)
                ST_RECV: begin
                    if (scl_rise && q.nbits < 4'd8) begin
                        d.shf   = {q.shf[6:0], sda_lvl};
                        d.nbits = q.nbits + 4'd1;
                    end else if (scl_fall && q.nbits == 4'd8) begin
                        if (q.kind == K_ADDR && q.shf != DEV_ADDR) begin
                            d.st = ST_IGNORE;
                        end else begin
                            d.st = ST_ACK;
                            d.oe = 1'b1;
                            if (q.kind == K_CNT) begin
                                d.cnt_ok = (q.shf != 8'd0) && (q.shf <= MAX_COUNT);
                                d.left   = q.shf[5:0];
                            end else if (q.kind == K_DATA && q.cnt_ok && q.left != 6'd0) begin
                                d.left = q.left - 6'd1;
                                d.idx  = q.idx + 6'd1;
                                if (q.idx < 6'(NREG)) begin
                                    d.wr    = 1'b1;
                                    d.widx  = q.idx[IDX_W-1:0];
                                    d.wdata = q.shf;
                                end
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.st    = ST_RECV;
                        d.nbits = '0;
                        case (q.kind)
                            K_ADDR:  d.kind = K_CMD;
                            K_CMD:   d.kind = K_CNT;
                            default: d.kind = K_DATA;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr;
    assign wr_idx  = q.widx;
    assign wr_data = q.wdata;

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    p_ack_fall_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && scl_fall && !start_det && !stop_det) |=> !sda_oe);
    p_write_needs_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> q.cnt_ok);
    p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NREG)));
endmodule

// File: rtl/cfgwr_regs.sv
module cfgwr_regs
    import cfgwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    output logic             ss_en,
    output logic             dot_en,
    output logic             usb_en,
    output logic             agp_en,
    output logic             pci1_en,
    output logic [MEM_N-1:0] mem_en
);
    logic [NREG-1:0][7:0] bank_d, bank_q;

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        always_comb begin
            bank_d[g] = bank_q[g];
            if (wr_en && wr_idx == IDX_W'(g))
                bank_d[g] = wr_data & BIT_MASK[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= RST_VAL;
        else        bank_q <= bank_d;
    end

    assign ss_en   = bank_q[0][3];
    assign dot_en  = bank_q[0][2];
    assign usb_en  = bank_q[0][1];
    assign mem_en  = {bank_q[2][6:2], bank_q[1]};
    assign agp_en  = bank_q[2][7];
    assign pci1_en = bank_q[2][1];

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));
    p_byte0_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> (ss_en == $past(wr_data[3])));
    p_byte1_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(1)) |=> (mem_en[7:0] == $past(wr_data)));
endmodule

// File: rtl/cfgwr_slave.sv
module cfgwr_slave
    import cfgwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    output logic        ss_en_o,
    output logic        dot_en_o,
    output logic        usb_en_o,
    output logic        agp_en_o,
    output logic        pci1_en_o,
    output logic [12:0] mem_en_o
);
    logic [1:0] line_raw, line_lvl, line_prv;
    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        cfgwr_sync #(.STAGES(2)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(line_raw[g]),
            .q(line_lvl[g]), .q_prev(line_prv[g])
        );
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  =  line_lvl[0] & ~line_prv[0];
    assign scl_fall  = ~line_lvl[0] &  line_prv[0];
    assign start_det =  line_lvl[0] & line_prv[0] &  line_prv[1] & ~line_lvl[1];
    assign stop_det  =  line_lvl[0] & line_prv[0] & ~line_prv[1] &  line_lvl[1];

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    cfgwr_link u_link (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(line_lvl[1]),
        .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    cfgwr_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ss_en(ss_en_o), .dot_en(dot_en_o), .usb_en(usb_en_o),
        .agp_en(agp_en_o), .pci1_en(pci1_en_o), .mem_en(mem_en_o)
    );
endmodule

// File: tb/cfgwr_slave_tb.sv
module cfgwr_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 10;

    logic clk = 0, rst_n = 0;
    logic scl = 1, sda_drv = 1;
    logic sda_oe;
    logic ss_en, dot_en, usb_en, agp_en, pci1_en;
    logic [12:0] mem_en;
    wire  sda_line = sda_drv & ~sda_oe;

    int n_checks = 0, n_errors = 0;
    logic [7:0] m0, m1, m2;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgwr_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .ss_en_o(ss_en), .dot_en_o(dot_en), .usb_en_o(usb_en),
        .agp_en_o(agp_en), .pci1_en_o(pci1_en), .mem_en_o(mem_en)
    );

    function automatic logic [17:0] exp_vec(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
        return {b0[3], b0[2], b0[1], b2[7], b2[1], b2[6:2], b1};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_outs(string req);
        wt(8);
        check(req, 32'({ss_en, dot_en, usb_en, agp_en, pci1_en, mem_en}), 32'(exp_vec(m0, m1, m2)));
    endtask

    task automatic bus_start();
        if (scl == 1'b0) begin
            wt(2); sda_drv = 1; wt(HALF); scl = 1; wt(HALF);
        end
        sda_drv = 0; wt(HALF); scl = 0;
    endtask

    task automatic bus_stop();
        wt(2); sda_drv = 0; wt(HALF); scl = 1; wt(HALF); sda_drv = 1; wt(HALF);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wt(2); sda_drv = b[i]; wt(HALF - 2); scl = 1; wt(HALF); scl = 0;
        end
        wt(2); sda_drv = 1; wt(HALF - 2); scl = 1; wt(HALF / 2);
        acked = ~sda_line;
        wt(HALF / 2); scl = 0;
    endtask

    // Whole transfer with model update. nd = data bytes sent; hdr = header bytes sent (1..3)
    task automatic txn(string req, logic [7:0] addr, logic [7:0] cmd, logic [7:0] cnt,
                       int hdr, int nd, logic [7:0] dat [8], bit do_stop);
        logic ack;
        bit ok, cok;
        ok = (addr == 8'hD2);
        cok = ok && (cnt != 0) && (cnt <= 32);
        bus_start();
        send_byte(addr, ack); check({req, " R2 addr ack"}, 32'(ack), 32'(ok));
        if (hdr > 1) begin send_byte(cmd, ack); check({req, " R3 cmd ack"}, 32'(ack), 32'(ok)); end
        if (hdr > 2) begin
            send_byte(cnt, ack); check({req, " R4 cnt ack"}, 32'(ack), 32'(ok));
            for (int i = 0; i < nd; i++) begin
                send_byte(dat[i], ack);
                check({req, " R6 data ack"}, 32'(ack), 32'(ok));
                if (cok && i < int'(cnt)) begin
                    if (i == 0) m0 = dat[i] & 8'h0E;
                    if (i == 1) m1 = dat[i];
                    if (i == 2) m2 = dat[i] & 8'hFE;
                end
            end
        end
        if (do_stop) begin
            bus_stop();
            check({req, " R10 released"}, 32'(sda_oe), 32'(0));
            check_outs(req);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d [8];
        void'($urandom(32'h5EED1234));
        m0 = 8'h06; m1 = 8'hFF; m2 = 8'hFE;
        wt(5); rst_n = 1; wt(5);
        check("R1 reset oe", 32'(sda_oe), 32'(0));
        check_outs("R1 reset outputs");

        // R4 R8 R9 full write, MSB first
        d = '{8'hFF, 8'h5A, 8'hA5, 0, 0, 0, 0, 0};
        txn("R8 R9 full", 8'hD2, 8'h00, 8'd3, 3, 3, d, 1);
        check("R8 ss/dot/usb", 32'({ss_en, dot_en, usb_en}), 32'(3'b111));
        check("R9 mem low", 32'(mem_en[7:0]), 32'(8'h5A));
        // R3 nonzero command ignored
        d = '{8'h08, 8'h00, 8'h00, 0, 0, 0, 0, 0};
        txn("R3 cmd value", 8'hD2, 8'h77, 8'd3, 3, 3, d, 1);
        // R2 foreign address
        d = '{8'h0E, 8'hFF, 8'hFE, 0, 0, 0, 0, 0};
        txn("R2 foreign", 8'hD4, 8'h00, 8'd3, 3, 3, d, 1);
        // R5 count 0 and count 33
        txn("R5 count0", 8'hD2, 8'h00, 8'd0, 3, 3, d, 1);
        txn("R5 count33", 8'hD2, 8'h00, 8'd33, 3, 3, d, 1);
        // R6 bytes past count and past byte 2
        d = '{8'h02, 8'h11, 8'h22, 0, 0, 0, 0, 0};
        txn("R6 past count", 8'hD2, 8'h00, 8'd2, 3, 3, d, 1);
        d = '{8'h04, 8'h33, 8'h44, 8'hFF, 8'hFF, 0, 0, 0};
        txn("R6 reserved", 8'hD2, 8'h00, 8'd5, 3, 5, d, 1);
        // R7 stop after byte 0
        d = '{8'h0A, 8'h00, 8'h00, 0, 0, 0, 0, 0};
        txn("R7 early stop", 8'hD2, 8'h00, 8'd3, 3, 1, d, 1);
        // R11 repeated start: partial then restart at byte 0
        d = '{8'h0C, 8'h99, 0, 0, 0, 0, 0, 0};
        txn("R11 first", 8'hD2, 8'h00, 8'd3, 3, 2, d, 0);
        d = '{8'h02, 8'h66, 0, 0, 0, 0, 0, 0};
        txn("R11 restart", 8'hD2, 8'h00, 8'd2, 3, 2, d, 1);
        check("R11 byte1 from restart", 32'(mem_en[7:0]), 32'(8'h66));

        for (int t = 0; t < 24; t++) begin
            logic [7:0] ad, cn;
            int nd, hd;
            ad = ($urandom % 5 == 0) ? 8'($urandom) & 8'hFE : 8'hD2;
            cn = 8'($urandom % 36);
            hd = ($urandom % 6 == 0) ? 1 + int'($urandom % 2) : 3;
            nd = int'($urandom % 7);
            for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
            txn("R4 random", ad, 8'($urandom), cn, hd, nd, d, 1);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule